// File: doc/BRIEF.md
# Remapping Unit Global Command Controller

This block holds the global command and status register pair of an I/O address and interrupt remapping unit. Software writes one-shot requests to a command register: set the interrupt remap table pointer, switch interrupt remapping on or off, and switch queued invalidation on or off. The block carries out each request and reports the result only in a separate status register. Status bits do not follow the write. They change only when the operation has actually completed.

A pointer request copies the table address register into the active pointer output within one cycle. An enable change first asks the request pipeline to drain. The block raises `drain_req` and holds it until the pipeline answers with `drain_ack`. The new enable state is committed on the cycle after that answer. Every in-flight DMA or interrupt request is therefore handled entirely under the old setting or entirely under the new one. A command write that arrives while an operation is pending is stalled with `bus_ready` low, so commands complete one at a time in arrival order.

Writes to the direct invalidation register are forwarded to the invalidation logic only while queued invalidation is off. While queued invalidation is on, they are rejected with a one-cycle flag.

The state machine has three states:
- `ST_IDLE`: waits for a command write.
- `ST_PTR`: commits the pointer for one cycle.
- `ST_DRAIN`: holds the drain request until it is acknowledged.

It has these transitions:
- `ST_IDLE` to `ST_PTR` on a command that sets the pointer.
- `ST_IDLE` to `ST_DRAIN` on a command that changes an enable but does not set the pointer.
- `ST_PTR` to `ST_DRAIN` when the same command also changes an enable.
- `ST_PTR` to `ST_IDLE` otherwise.
- `ST_DRAIN` to `ST_IDLE` on `drain_ack`.

Top module: `remap_gcmd_ctrl`

## Requirements
- R1: After reset, the status register, the active pointer, `ir_active`, `qi_active`, `drain_req`, `dinv_valid` and `dinv_reject` are all 0.
- R2: A command write with bit 24 set copies the value the table address register held at that write into `table_ptr` and sets status bit 24. It causes no drain. `table_ptr` changes at no other time.
- R3: Command bits are not stored as readable state, and a read of the command register returns 0. A command write with bit 24 clear leaves `table_ptr` and status bit 24 unchanged.
- R4: A command write whose bit 25 differs from status bit 25 starts a drain. Status bit 25 and `ir_active` take the written value on the cycle after `drain_ack` is seen, and they do not change at any other time.
- R5: A command write whose bit 26 differs from status bit 26 starts a drain. Status bit 26 and `qi_active` take the written value on the cycle after `drain_ack` is seen, and they do not change at any other time.
- R6: A command write whose bits 25 and 26 both equal the current status starts no drain.
- R7: Once raised, `drain_req` stays high until the cycle in which `drain_ack` is high, and it is low on the next cycle.
- R8: While an operation is pending, a command write sees `bus_ready` low and is held off. It is accepted when the block returns to idle, and it is then executed after the earlier operation.
- R9: A write to the direct invalidation register gives a one-cycle `dinv_valid` carrying the written data on the next cycle, provided `qi_active` is 0. If `qi_active` is 1, the write instead gives a one-cycle `dinv_reject` and no `dinv_valid`.
- R10: Command register bits other than 24, 25 and 26 have no effect.
- R11: The register offsets are: command 0x0, status 0x4, table address 0x8 and direct invalidation 0xC. The status and table address registers read back their values. Reads of the other offsets return 0. Status bit 24 means pointer set, bit 25 means interrupt remapping enabled and bit 26 means queued invalidation enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | OFS_W | Register byte offset |
| bus_wdata | input | REG_W | Write data |
| bus_ready | output | 1 | Access accepted; low while a command write is held off |
| bus_rdata | output | REG_W | Read data, valid in the same cycle as a read request |
| drain_req | output | 1 | Request to drain the DMA and interrupt pipeline |
| drain_ack | input | 1 | Pipeline is drained at a request boundary |
| table_ptr | output | REG_W | Active interrupt remap table pointer |
| ir_active | output | 1 | Interrupt remapping is in effect |
| qi_active | output | 1 | Queued invalidation is in effect |
| dinv_valid | output | 1 | Forwarded direct invalidation command |
| dinv_data | output | REG_W | Data of the forwarded direct invalidation command |
| dinv_reject | output | 1 | A direct invalidation write was refused |

## Verification
The assertions check the following on every cycle:
- the drain handshake shape;
- that the enable outputs move only on an acknowledged drain;
- that the pointer moves only in its commit cycle;
- the stall of command writes while an operation is pending;
- that a forward and a reject of a direct invalidation never coincide with the wrong enable state;
- that command reads return zero.

Only the bench scenarios can show the rest: that the committed values match what software wrote, and that a combined pointer-and-enable command ends in the right final state. They also show that a held-off command executes after the earlier one, that ignored command bits change nothing, and that no drain is started when the enables are unchanged.

// File: rtl/rgc_pkg.sv
package rgc_pkg;

    // Register byte offsets
    localparam int OFS_CMD  = 'h0;
    localparam int OFS_STS  = 'h4;
    localparam int OFS_TBL  = 'h8;
    localparam int OFS_DINV = 'hC;

    // Command / status bit positions (software decodes these)
    localparam int BIT_PTR = 24;
    localparam int BIT_IRE = 25;
    localparam int BIT_QIE = 26;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PTR   = 2'd1,
        ST_DRAIN = 2'd2
    } gc_state_e;

    typedef struct packed {
        logic set_ptr;
        logic ire;
        logic qie;
    } gc_cmd_t;

endpackage

// File: rtl/rgc_regs.sv
module rgc_regs
    import rgc_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int OFS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             busy,
    input  logic [REG_W-1:0] status_word,
    output logic             bus_ready,
    output logic [REG_W-1:0] bus_rdata,
    output logic             cmd_fire,
    output gc_cmd_t          cmd_bits,
    output logic [REG_W-1:0] tbl_q,
    output logic             dinv_wr,
    output logic [REG_W-1:0] dinv_wdata
);

    localparam logic [OFS_W-1:0] A_CMD  = OFS_W'(OFS_CMD);
    localparam logic [OFS_W-1:0] A_STS  = OFS_W'(OFS_STS);
    localparam logic [OFS_W-1:0] A_TBL  = OFS_W'(OFS_TBL);
    localparam logic [OFS_W-1:0] A_DINV = OFS_W'(OFS_DINV);

    logic sel_cmd;
    logic sel_sts;
    logic sel_tbl;
    logic sel_dinv;
    logic acc_wr;

    assign sel_cmd  = (bus_addr == A_CMD);
    assign sel_sts  = (bus_addr == A_STS);
    assign sel_tbl  = (bus_addr == A_TBL);
    assign sel_dinv = (bus_addr == A_DINV);

    // Only command writes are held off while an operation is pending
    assign bus_ready = !(bus_valid && bus_write && sel_cmd && busy);
    assign acc_wr    = bus_valid && bus_write && bus_ready;

    assign cmd_fire         = acc_wr && sel_cmd;
    assign cmd_bits.set_ptr = bus_wdata[BIT_PTR];
    assign cmd_bits.ire     = bus_wdata[BIT_IRE];
    assign cmd_bits.qie     = bus_wdata[BIT_QIE];

    assign dinv_wr    = acc_wr && sel_dinv;
    assign dinv_wdata = bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else if (acc_wr && sel_tbl) begin
            tbl_q <= bus_wdata;
        end
    end

    // Command and direct-invalidation offsets read as zero
    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            if (sel_sts) begin
                bus_rdata = status_word;
            end else if (sel_tbl) begin
                bus_rdata = tbl_q;
            end
        end
    end

endmodule

// File: rtl/rgc_fsm.sv
module rgc_fsm
    import rgc_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_fire,
    input  gc_cmd_t          cmd_bits,
    input  logic [PTR_W-1:0] tbl_addr,
    input  logic             drain_ack,
    output logic             busy,
    output logic             drain_req,
    output logic             ptr_load,
    output logic             ir_en,
    output logic             qi_en,
    output logic             ptr_done,
    output logic [PTR_W-1:0] table_ptr
);

    gc_state_e state_q;
    gc_state_e state_d;

    logic             pend_ire;
    logic             pend_qie;
    logic             pend_change;
    logic [PTR_W-1:0] pend_ptr;
    logic             want_change;

    assign want_change = (cmd_bits.ire != ir_en) || (cmd_bits.qie != qi_en);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_fire) begin
                    if (cmd_bits.set_ptr) begin
                        state_d = ST_PTR;
                    end else if (want_change) begin
                        state_d = ST_DRAIN;
                    end
                end
            end
            ST_PTR: begin
                state_d = pend_change ? ST_DRAIN : ST_IDLE;
            end
            ST_DRAIN: begin
                if (drain_ack) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        drain_req = (state_q == ST_DRAIN);
        ptr_load  = (state_q == ST_PTR);
    end

    // Pending command capture and status commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_ire    <= 1'b0;
            pend_qie    <= 1'b0;
            pend_change <= 1'b0;
            pend_ptr    <= '0;
            ir_en       <= 1'b0;
            qi_en       <= 1'b0;
            ptr_done    <= 1'b0;
            table_ptr   <= '0;
        end else begin
            if (state_q == ST_IDLE && cmd_fire) begin
                pend_ire    <= cmd_bits.ire;
                pend_qie    <= cmd_bits.qie;
                pend_change <= want_change;
                if (cmd_bits.set_ptr) begin
                    pend_ptr <= tbl_addr;
                    ptr_done <= 1'b0;
                end
            end
            if (ptr_load) begin
                table_ptr <= pend_ptr;
                ptr_done  <= 1'b1;
            end
            if (drain_req && drain_ack) begin
                ir_en <= pend_ire;
                qi_en <= pend_qie;
            end
        end
    end

endmodule

// File: rtl/rgc_dinv_gate.sv
module rgc_dinv_gate #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dinv_wr,
    input  logic [REG_W-1:0] dinv_wdata,
    input  logic             qi_en,
    output logic             dinv_valid,
    output logic [REG_W-1:0] dinv_data,
    output logic             dinv_reject
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dinv_valid  <= 1'b0;
            dinv_reject <= 1'b0;
            dinv_data   <= '0;
        end else begin
            dinv_valid  <= dinv_wr && !qi_en;
            dinv_reject <= dinv_wr && qi_en;
            if (dinv_wr && !qi_en) begin
                dinv_data <= dinv_wdata;
            end
        end
    end

endmodule

// File: rtl/remap_gcmd_ctrl.sv
module remap_gcmd_ctrl
    import rgc_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int OFS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic             bus_ready,
    output logic [REG_W-1:0] bus_rdata,
    output logic             drain_req,
    input  logic             drain_ack,
    output logic [REG_W-1:0] table_ptr,
    output logic             ir_active,
    output logic             qi_active,
    output logic             dinv_valid,
    output logic [REG_W-1:0] dinv_data,
    output logic             dinv_reject
);

    logic             busy;
    logic             cmd_fire;
    gc_cmd_t          cmd_bits;
    logic [REG_W-1:0] tbl_q;
    logic             dinv_wr;
    logic [REG_W-1:0] dinv_wdata;
    logic             ptr_load;
    logic             ptr_done;
    logic [REG_W-1:0] status_word;

    always_comb begin
        status_word          = '0;
        status_word[BIT_PTR] = ptr_done;
        status_word[BIT_IRE] = ir_active;
        status_word[BIT_QIE] = qi_active;
    end

    rgc_regs #(
        .REG_W (REG_W),
        .OFS_W (OFS_W)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .busy        (busy),
        .status_word (status_word),
        .bus_ready   (bus_ready),
        .bus_rdata   (bus_rdata),
        .cmd_fire    (cmd_fire),
        .cmd_bits    (cmd_bits),
        .tbl_q       (tbl_q),
        .dinv_wr     (dinv_wr),
        .dinv_wdata  (dinv_wdata)
    );

    rgc_fsm #(
        .PTR_W (REG_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_fire  (cmd_fire),
        .cmd_bits  (cmd_bits),
        .tbl_addr  (tbl_q),
        .drain_ack (drain_ack),
        .busy      (busy),
        .drain_req (drain_req),
        .ptr_load  (ptr_load),
        .ir_en     (ir_active),
        .qi_en     (qi_active),
        .ptr_done  (ptr_done),
        .table_ptr (table_ptr)
    );

    rgc_dinv_gate #(
        .REG_W (REG_W)
    ) i_dinv (
        .clk         (clk),
        .rst_n       (rst_n),
        .dinv_wr     (dinv_wr),
        .dinv_wdata  (dinv_wdata),
        .qi_en       (qi_active),
        .dinv_valid  (dinv_valid),
        .dinv_data   (dinv_data),
        .dinv_reject (dinv_reject)
    );

endmodule

// File: rtl/rgc_checker.sv
module rgc_checker
    import rgc_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int OFS_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [OFS_W-1:0] bus_addr,
    input logic             bus_ready,
    input logic [REG_W-1:0] bus_rdata,
    input logic             drain_req,
    input logic             drain_ack,
    input logic [REG_W-1:0] table_ptr,
    input logic             ir_active,
    input logic             qi_active,
    input logic             dinv_valid,
    input logic             dinv_reject,
    input logic             ptr_load,
    input logic             cmd_fire,
    input gc_cmd_t          cmd_bits
);

    localparam logic [OFS_W-1:0] A_CMD = OFS_W'(OFS_CMD);

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req && !drain_ack |=> drain_req); // R7
    AST_DRAIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req && drain_ack |=> !drain_req); // R7
    AST_IR_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(drain_req && drain_ack) |=> $stable(ir_active)); // R4
    AST_QI_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(drain_req && drain_ack) |=> $stable(qi_active)); // R5
    AST_PTR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_load |=> $stable(table_ptr)); // R2
    AST_CMD_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && bus_addr == A_CMD && drain_req |-> !bus_ready); // R8
    AST_NO_SPURIOUS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire && !cmd_bits.set_ptr && cmd_bits.ire == ir_active
        && cmd_bits.qie == qi_active |=> !drain_req); // R6
    AST_DINV_FWD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dinv_valid |-> !$past(qi_active) && !dinv_reject); // R9
    AST_DINV_REJ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dinv_reject |-> $past(qi_active)); // R9
    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write && bus_addr == A_CMD |-> bus_rdata == '0); // R3

endmodule

bind remap_gcmd_ctrl rgc_checker #(
    .REG_W (REG_W),
    .OFS_W (OFS_W)
) i_rgc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_ready   (bus_ready),
    .bus_rdata   (bus_rdata),
    .drain_req   (drain_req),
    .drain_ack   (drain_ack),
    .table_ptr   (table_ptr),
    .ir_active   (ir_active),
    .qi_active   (qi_active),
    .dinv_valid  (dinv_valid),
    .dinv_reject (dinv_reject),
    .ptr_load    (ptr_load),
    .cmd_fire    (cmd_fire),
    .cmd_bits    (cmd_bits)
);

// File: tb/test_remap_gcmd_ctrl.sv
`timescale 1ns/1ps
module test_remap_gcmd_ctrl;

    localparam int REG_W = 32;
    localparam int OFS_W = 4;
    localparam logic [OFS_W-1:0] O_CMD  = 4'h0;
    localparam logic [OFS_W-1:0] O_STS  = 4'h4;
    localparam logic [OFS_W-1:0] O_TBL  = 4'h8;
    localparam logic [OFS_W-1:0] O_DINV = 4'hC;
    localparam int NVEC = 9;

    // {table addr, command, expected status, expected pointer, expected drains}
    localparam logic [159:0] VEC [NVEC] = '{
        {32'h0000_1000, 32'h0100_0000, 32'h0100_0000, 32'h0000_1000, 32'd0},
        {32'h0000_2000, 32'h0200_0000, 32'h0300_0000, 32'h0000_1000, 32'd1},
        {32'h0000_3000, 32'h0700_0000, 32'h0700_0000, 32'h0000_3000, 32'd1},
        {32'h0000_4000, 32'h0600_0000, 32'h0700_0000, 32'h0000_3000, 32'd0},
        {32'h0000_5000, 32'h0000_0000, 32'h0100_0000, 32'h0000_3000, 32'd1},
        {32'h0000_6000, 32'h0500_0000, 32'h0500_0000, 32'h0000_6000, 32'd1},
        {32'h0000_6000, 32'h0400_0000, 32'h0500_0000, 32'h0000_6000, 32'd0},
        {32'h0000_7000, 32'h0000_0000, 32'h0100_0000, 32'h0000_6000, 32'd1},
        {32'h0000_8000, 32'hF8FF_FFFF, 32'h0100_0000, 32'h0000_6000, 32'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [OFS_W-1:0] bus_addr = '0;
    logic [REG_W-1:0] bus_wdata = '0;
    logic             bus_ready;
    logic [REG_W-1:0] bus_rdata;
    logic             drain_req;
    logic             drain_ack = 1'b0;
    logic [REG_W-1:0] table_ptr;
    logic             ir_active;
    logic             qi_active;
    logic             dinv_valid;
    logic [REG_W-1:0] dinv_data;
    logic             dinv_reject;

    int   n_chk = 0;
    int   n_fail = 0;
    int   drains = 0;
    logic auto_ack = 1'b1;
    int   ack_dly = 1;
    logic [REG_W-1:0] rd;

    always #2.5 clk = ~clk;

    remap_gcmd_ctrl #(
        .REG_W (REG_W),
        .OFS_W (OFS_W)
    ) i_remap_gcmd_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_ready   (bus_ready),
        .bus_rdata   (bus_rdata),
        .drain_req   (drain_req),
        .drain_ack   (drain_ack),
        .table_ptr   (table_ptr),
        .ir_active   (ir_active),
        .qi_active   (qi_active),
        .dinv_valid  (dinv_valid),
        .dinv_data   (dinv_data),
        .dinv_reject (dinv_reject)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic bus_wr(input logic [OFS_W-1:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        #1;
        while (!bus_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [OFS_W-1:0] a, output logic [REG_W-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b0;
        bus_addr  = a;
        #1;
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    // Automatic drain responder
    initial begin
        forever begin
            @(negedge clk);
            if (auto_ack && drain_req && !drain_ack) begin
                repeat (ack_dly) @(negedge clk);
                drain_ack = 1'b1;
                @(negedge clk);
                drain_ack = 1'b0;
            end
        end
    end

    // Count completed handshakes
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (drain_req && drain_ack) drains++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(O_STS, rd);
        chk("R1 status", rd, 32'h0);
        chk("R1 table_ptr", table_ptr, 32'h0);
        chk("R1 drain_req/ir/qi", {29'h0, drain_req, ir_active, qi_active}, 32'h0);
        chk("R1 dinv", {30'h0, dinv_valid, dinv_reject}, 32'h0);

        // Vector table: R2 R4 R5 R6 R10
        for (int i = 0; i < NVEC; i++) begin
            int d0;
            ack_dly = i % 4;
            d0 = drains;
            bus_wr(O_TBL, VEC[i][159:128]);
            bus_wr(O_CMD, VEC[i][127:96]);
            repeat (12) @(negedge clk);
            bus_rd(O_STS, rd);
            chk($sformatf("R4/R5 status vec%0d", i), rd, VEC[i][95:64]);
            chk($sformatf("R2 pointer vec%0d", i), table_ptr, VEC[i][63:32]);
            chk($sformatf("R6 drain count vec%0d", i), drains - d0, VEC[i][31:0]);
            chk($sformatf("R4/R5 outputs vec%0d", i), {30'h0, qi_active, ir_active},
                {30'h0, VEC[i][90], VEC[i][89]});
        end

        // R11 readback of table address, R3 command reads zero
        bus_rd(O_TBL, rd);
        chk("R11 table readback", rd, 32'h0000_8000);
        bus_rd(O_CMD, rd);
        chk("R3 command read", rd, 32'h0);
        bus_rd(O_DINV, rd);
        chk("R11 dinv read", rd, 32'h0);

        // Hold-off and ordering: R4 R7 R8
        auto_ack = 1'b0;
        bus_wr(O_CMD, 32'h0200_0000);
        repeat (5) @(negedge clk);
        chk("R7 drain_req held", {31'h0, drain_req}, 32'h1);
        chk("R4 ir before ack", {31'h0, ir_active}, 32'h0);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = O_CMD;
        bus_wdata = 32'h0600_0000;
        #1;
        chk("R8 ready low while pending", {31'h0, bus_ready}, 32'h0);
        repeat (3) @(negedge clk);
        #1;
        chk("R8 still held", {31'h0, bus_ready}, 32'h0);
        chk("R5 qi unchanged while held", {31'h0, qi_active}, 32'h0);
        @(negedge clk);
        drain_ack = 1'b1;
        @(negedge clk);
        chk("R4 ir after ack", {31'h0, ir_active}, 32'h1);
        chk("R7 drain_req dropped", {31'h0, drain_req}, 32'h0);
        drain_ack = 1'b0;
        #1;
        chk("R8 ready when idle", {31'h0, bus_ready}, 32'h1);
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        chk("R8 held command now draining", {31'h0, drain_req}, 32'h1);
        chk("R5 qi before second ack", {31'h0, qi_active}, 32'h0);
        repeat (2) @(negedge clk);
        drain_ack = 1'b1;
        @(negedge clk);
        drain_ack = 1'b0;
        chk("R5 qi after second ack", {30'h0, qi_active, ir_active}, 32'h3);

        // R9 direct invalidation gating
        bus_wr(O_DINV, 32'h0000_ABCD);
        chk("R9 reject while queued", {30'h0, dinv_valid, dinv_reject}, 32'h1);
        @(negedge clk);
        chk("R9 reject one cycle", {30'h0, dinv_valid, dinv_reject}, 32'h0);
        auto_ack = 1'b1;
        ack_dly = 2;
        bus_wr(O_CMD, 32'h0000_0000);
        repeat (10) @(negedge clk);
        chk("R5 queued off", {30'h0, qi_active, ir_active}, 32'h0);
        bus_wr(O_DINV, 32'h0000_1234);
        chk("R9 forward valid", {30'h0, dinv_valid, dinv_reject}, 32'h2);
        chk("R9 forward data", dinv_data, 32'h0000_1234);
        @(negedge clk);
        chk("R9 forward one cycle", {31'h0, dinv_valid}, 32'h0);

        // R1 reset during operation
        bus_wr(O_TBL, 32'h0000_9000);
        bus_wr(O_CMD, 32'h0300_0000);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_rd(O_STS, rd);
        chk("R1 status after reset", rd, 32'h0);
        chk("R1 pointer after reset", table_ptr, 32'h0);

        finish_run();
    end

endmodule